// File: doc/BRIEF.md
# Event-to-Counter Binding Table

This block holds a small associative table that records which programmable performance counter is currently attached to each hardware event code. A write to one counter's event selector is presented on the write port. The block takes the event code from the low 20 bits of the selector value and does one of four things. It adds a binding for a new code, keeps an older binding for a code that is already present, rejects an unsupported code, or deletes every binding that points at that counter when the whole selector value is zero.

A second, purely combinational port takes an incoming event code and returns a hit flag together with the bound counter index. The surrounding logic uses that result to steer increment pulses. Two monitor outputs report whether a given counter is counting cycles or retired instructions. Counter 0 always counts cycles and counter 2 always counts instructions. A programmable counter also qualifies when the cycle code or the instruction code is bound to it.

Top module: `evt_ctr_map`

## Requirements
- R1: After reset the table is empty, so every lookup misses.
- R2: The event code is bits [19:0] of the 64-bit selector value. Bits [63:20] only matter when deciding whether the whole value is zero.
- R3: A write of a nonzero value to an available counter inserts a binding when its code is supported and not yet present. A lookup of that code then hits and returns the counter index.
- R4: When a code already has a binding, a write of that code to any other counter leaves the existing binding unchanged.
- R5: Only the codes 0x00001 (cycles), 0x00002 (instructions), 0x10019, 0x1001B and 0x10021 are accepted. Any other code, including 0x00000 with nonzero upper bits, creates no entry.
- R6: A write whose full 64-bit value is zero removes every binding held by that counter index. Bindings held by other counters are left in place.
- R7: A write is ignored when its counter index is below 3, or when the index lies outside the available set. The available set is indices 3 to 3+NUM_PROG-1; with the default NUM_PROG of 8 that is 3 to 10.
- R8: A lookup miss drives look_hit low and look_ctr to zero.
- R9: mon_cycles is high when mon_ctr is 0 or is the counter bound to code 0x00001. mon_instret is high when mon_ctr is 2 or is the counter bound to code 0x00002.
- R10: An insert or remove takes effect at the clock edge that samples the write. Lookup and monitor outputs show the change in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_wr_en | input | 1 | Event selector write strobe |
| sel_wr_idx | input | 5 | Counter index being written |
| sel_wr_val | input | 64 | Selector value written |
| look_evt | input | 20 | Event code to look up |
| look_hit | output | 1 | The looked-up code has a binding |
| look_ctr | output | 5 | Bound counter index, zero on miss |
| mon_ctr | input | 5 | Counter index queried by the monitor outputs |
| mon_cycles | output | 1 | The queried counter counts cycles |
| mon_instret | output | 1 | The queried counter counts instructions |

## Verification
The table registers change on the rising edge that samples a write. Both the lookup result and the two monitor flags are combinational from the table, so every effect of a write is due in the first cycle after that edge and not earlier. The bench drives inputs at the falling edge and compares the outputs one nanosecond later against a queue-based model. The model absorbs the write only after the rising edge, so each comparison sees exactly the state before the pending write. The check immediately after a write therefore pins down its one-cycle latency.

// File: rtl/evt_ctr_map_pkg.sv
package evt_ctr_map_pkg;
  localparam int EVT_W      = 20;
  localparam int CIX_W      = 5;
  localparam int FIRST_PROG = 3;
  localparam logic [EVT_W-1:0] CODE_CYC = 20'h00001;
  localparam logic [EVT_W-1:0] CODE_INS = 20'h00002;
  localparam logic [CIX_W-1:0] FIX_CYC_IX = 5'd0;
  localparam logic [CIX_W-1:0] FIX_INS_IX = 5'd2;

  // Accepted event codes
  function automatic logic code_ok(input logic [EVT_W-1:0] k);
    case (k)
      20'h00001, 20'h00002, 20'h10019, 20'h1001B, 20'h10021: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Programmable counters: n consecutive indices from FIRST_PROG upward
  function automatic logic [31:0] avail_mask(input int n);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++)
      if (i >= FIRST_PROG && i < FIRST_PROG + n) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/evt_ctr_map_wrqual.sv
module evt_ctr_map_wrqual
  import evt_ctr_map_pkg::*;
#(
  parameter int NUM_PROG = 8,
  parameter int SEL_W    = 64
) (
  input  logic             wr_en,
  input  logic [CIX_W-1:0] wr_idx,
  input  logic [SEL_W-1:0] wr_val,
  output logic             wr_acc,
  output logic             val_zero,
  output logic [EVT_W-1:0] wr_key,
  output logic             key_ok
);
  localparam logic [31:0] AVAIL = avail_mask(NUM_PROG);

  logic idx_ok;

  always_comb begin
    idx_ok   = (wr_idx >= CIX_W'(FIRST_PROG)) && AVAIL[wr_idx];
    wr_acc   = wr_en && idx_ok;
    val_zero = (wr_val == '0);
    wr_key   = wr_val[EVT_W-1:0];
    key_ok   = code_ok(wr_key);
  end
endmodule

// File: rtl/evt_ctr_map_find.sv
module evt_ctr_map_find
  import evt_ctr_map_pkg::*;
#(
  parameter int ENTRIES = 29
) (
  input  logic [ENTRIES-1:0]            vld,
  input  logic [ENTRIES-1:0][EVT_W-1:0] keys,
  input  logic [ENTRIES-1:0][CIX_W-1:0] ctrs,
  input  logic [EVT_W-1:0]              key,
  output logic                          hit,
  output logic [CIX_W-1:0]              ctr
);
  // Parallel compare; lowest matching slot wins (keys are unique anyway)
  always_comb begin
    hit = 1'b0;
    ctr = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (vld[i] && keys[i] == key) begin
        hit = 1'b1;
        ctr = ctrs[i];
      end
    end
  end
endmodule

// File: rtl/evt_ctr_map_store.sv
module evt_ctr_map_store
  import evt_ctr_map_pkg::*;
#(
  parameter int ENTRIES = 29
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ins_en,
  input  logic [EVT_W-1:0]              ins_key,
  input  logic [CIX_W-1:0]              ins_ctr,
  input  logic                          rem_en,
  input  logic [CIX_W-1:0]              rem_ctr,
  output logic [ENTRIES-1:0]            vld,
  output logic [ENTRIES-1:0][EVT_W-1:0] keys,
  output logic [ENTRIES-1:0][CIX_W-1:0] ctrs,
  output logic                          has_free
);
  localparam int IX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [IX_W-1:0] free_ix;

  always_comb begin
    has_free = 1'b0;
    free_ix  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        has_free = 1'b1;
        free_ix  = IX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      keys <= '0;
      ctrs <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++)
        if (rem_en && vld[i] && ctrs[i] == rem_ctr) vld[i] <= 1'b0;
      if (ins_en) begin
        vld[free_ix]  <= 1'b1;
        keys[free_ix] <= ins_key;
        ctrs[free_ix] <= ins_ctr;
      end
    end
  end
endmodule

// File: rtl/evt_ctr_map.sv
module evt_ctr_map
  import evt_ctr_map_pkg::*;
#(
  parameter int ENTRIES  = 29,
  parameter int NUM_PROG = 8,
  parameter int SEL_W    = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_wr_en,
  input  logic [CIX_W-1:0] sel_wr_idx,
  input  logic [SEL_W-1:0] sel_wr_val,
  input  logic [EVT_W-1:0] look_evt,
  output logic             look_hit,
  output logic [CIX_W-1:0] look_ctr,
  input  logic [CIX_W-1:0] mon_ctr,
  output logic             mon_cycles,
  output logic             mon_instret
);
  logic                          wr_acc, val_zero, key_ok;
  logic [EVT_W-1:0]              wr_key;
  logic [ENTRIES-1:0]            ent_vld;
  logic [ENTRIES-1:0][EVT_W-1:0] ent_key;
  logic [ENTRIES-1:0][CIX_W-1:0] ent_ctr;
  logic                          has_free;
  logic                          key_present;
  logic [CIX_W-1:0]              key_owner;
  logic                          do_insert, do_remove;
  logic [1:0]                    mhit;
  logic [1:0][CIX_W-1:0]         mix;

  evt_ctr_map_wrqual #(.NUM_PROG(NUM_PROG), .SEL_W(SEL_W)) u_wrq (
    .wr_en(sel_wr_en), .wr_idx(sel_wr_idx), .wr_val(sel_wr_val),
    .wr_acc(wr_acc), .val_zero(val_zero), .wr_key(wr_key), .key_ok(key_ok)
  );

  evt_ctr_map_find #(.ENTRIES(ENTRIES)) u_wfind (
    .vld(ent_vld), .keys(ent_key), .ctrs(ent_ctr), .key(wr_key),
    .hit(key_present), .ctr(key_owner)
  );

  assign do_remove = wr_acc && val_zero;
  assign do_insert = wr_acc && !val_zero && key_ok && !key_present && has_free;

  evt_ctr_map_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ins_en(do_insert), .ins_key(wr_key), .ins_ctr(sel_wr_idx),
    .rem_en(do_remove), .rem_ctr(sel_wr_idx),
    .vld(ent_vld), .keys(ent_key), .ctrs(ent_ctr), .has_free(has_free)
  );

  evt_ctr_map_find #(.ENTRIES(ENTRIES)) u_lfind (
    .vld(ent_vld), .keys(ent_key), .ctrs(ent_ctr), .key(look_evt),
    .hit(look_hit), .ctr(look_ctr)
  );

  // Monitor units: slot 0 tracks the cycle code, slot 1 the instruction code
  for (genvar g = 0; g < 2; g++) begin : g_mon
    localparam logic [EVT_W-1:0] MKEY = (g == 0) ? CODE_CYC : CODE_INS;
    evt_ctr_map_find #(.ENTRIES(ENTRIES)) u_mfind (
      .vld(ent_vld), .keys(ent_key), .ctrs(ent_ctr), .key(MKEY),
      .hit(mhit[g]), .ctr(mix[g])
    );
  end

  assign mon_cycles  = (mon_ctr == FIX_CYC_IX) || (mhit[0] && mix[0] == mon_ctr);
  assign mon_instret = (mon_ctr == FIX_INS_IX) || (mhit[1] && mix[1] == mon_ctr);

  logic unused_owner;
  assign unused_owner = ^key_owner;
endmodule

// File: rtl/evt_ctr_map_chk.sv
module evt_ctr_map_chk
  import evt_ctr_map_pkg::*;
#(
  parameter int ENTRIES = 29,
  parameter int SEL_W   = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sel_wr_en,
  input logic [CIX_W-1:0]   sel_wr_idx,
  input logic [SEL_W-1:0]   sel_wr_val,
  input logic               look_hit,
  input logic [CIX_W-1:0]   look_ctr,
  input logic [CIX_W-1:0]   mon_ctr,
  input logic               mon_cycles,
  input logic               mon_instret,
  input logic [ENTRIES-1:0] ent_vld,
  input logic               do_insert,
  input logic               do_remove,
  input logic               key_present
);
  p_miss_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !look_hit |-> look_ctr == '0);

  p_low_idx_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr_en && sel_wr_idx < CIX_W'(FIRST_PROG) |=> $stable(ent_vld));

  p_unsupported_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr_en && sel_wr_val != '0 && !code_ok(sel_wr_val[EVT_W-1:0])
    |=> $stable(ent_vld));

  p_keep_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr_en && sel_wr_val != '0 && key_present |=> $stable(ent_vld));

  p_insert_grows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    do_insert |=> $countones(ent_vld) == $past($countones(ent_vld)) + 1);

  p_remove_shrinks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    do_remove |=> $countones(ent_vld) <= $past($countones(ent_vld)));

  p_fixed_cycles_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mon_ctr == FIX_CYC_IX |-> mon_cycles);

  p_fixed_instret_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mon_ctr == FIX_INS_IX |-> mon_instret);
endmodule

bind evt_ctr_map evt_ctr_map_chk #(.ENTRIES(ENTRIES), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_wr_en(sel_wr_en), .sel_wr_idx(sel_wr_idx),
  .sel_wr_val(sel_wr_val), .look_hit(look_hit), .look_ctr(look_ctr),
  .mon_ctr(mon_ctr), .mon_cycles(mon_cycles), .mon_instret(mon_instret),
  .ent_vld(ent_vld), .do_insert(do_insert), .do_remove(do_remove),
  .key_present(key_present)
);

// File: tb/evt_ctr_map_test.sv
module evt_ctr_map_test;
  localparam int NP = 8;
  localparam int NENT = 29;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel_wr_en;
  logic [4:0]  sel_wr_idx;
  logic [63:0] sel_wr_val;
  logic [19:0] look_evt;
  logic        look_hit;
  logic [4:0]  look_ctr;
  logic [4:0]  mon_ctr;
  logic        mon_cycles, mon_instret;

  always #4 clk = ~clk;   // 125 MHz

  evt_ctr_map #(.ENTRIES(NENT), .NUM_PROG(NP), .SEL_W(64)) uut (
    .clk(clk), .rst_n(rst_n), .sel_wr_en(sel_wr_en), .sel_wr_idx(sel_wr_idx),
    .sel_wr_val(sel_wr_val), .look_evt(look_evt), .look_hit(look_hit),
    .look_ctr(look_ctr), .mon_ctr(mon_ctr), .mon_cycles(mon_cycles),
    .mon_instret(mon_instret)
  );

  int n_chk = 0;
  int n_fail = 0;
  int qk[$];
  int qc[$];

  function automatic bit sup(int k);
    return k == 1 || k == 2 || k == 'h10019 || k == 'h1001B || k == 'h10021;
  endfunction

  function automatic bit avail(int ix);
    return ix >= 3 && ix < 3 + NP;
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic m_find(int key, output bit h, output int c);
    h = 0; c = 0;
    foreach (qk[i]) if (qk[i] == key) begin h = 1; c = qc[i]; end
  endtask

  task automatic m_write(int ix, longint unsigned v);
    bit h; int c; int key;
    if (!avail(ix)) return;
    if (v == 0) begin
      for (int i = qk.size() - 1; i >= 0; i--)
        if (qc[i] == ix) begin qk.delete(i); qc.delete(i); end
      return;
    end
    key = int'(v & 64'hFFFFF);
    m_find(key, h, c);
    if (h || !sup(key) || qk.size() >= NENT) return;
    qk.push_back(key);
    qc.push_back(ix);
  endtask

  task automatic step(bit wr, int ix, longint unsigned v, int look, int mon, string tag);
    bit h; int c; bit e;
    @(negedge clk);
    sel_wr_en = wr; sel_wr_idx = ix[4:0]; sel_wr_val = v;
    look_evt = look[19:0]; mon_ctr = mon[4:0];
    #1;
    m_find(look, h, c);
    chk(tag, "look_hit", look_hit, h);
    chk(h ? tag : "R8", "look_ctr", look_ctr, c);
    m_find(1, h, c);
    e = (mon == 0) || (h && c == mon);
    chk("R9", "mon_cycles", mon_cycles, e);
    m_find(2, h, c);
    e = (mon == 2) || (h && c == mon);
    chk("R9", "mon_instret", mon_instret, e);
    @(posedge clk);
    if (wr) m_write(ix, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; sel_wr_en = 0; sel_wr_idx = 0; sel_wr_val = 0; look_evt = 0; mon_ctr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1: empty after reset
    step(0, 0, 0, 1, 0, "R1");
    step(0, 0, 0, 2, 2, "R1");
    step(0, 0, 0, 'h10019, 5, "R1");
    // R3 insert, R10 visible next cycle
    step(1, 5, 64'h2, 2, 5, "R3");
    step(0, 0, 0, 2, 5, "R10");
    // R2 upper bits do not change the code
    step(1, 6, 64'hFFFF_0000_0000_0001, 1, 6, "R2");
    step(0, 0, 0, 1, 6, "R2");
    // R4 first binding kept
    step(1, 7, 64'h2, 2, 7, "R4");
    step(0, 0, 0, 2, 7, "R4");
    // R5 unsupported codes, and code zero with upper bits set
    step(1, 7, 64'h12345, 'h12345, 7, "R5");
    step(1, 8, 64'h0010_0000_0000_0000, 0, 8, "R5");
    step(0, 0, 0, 0, 8, "R5");
    step(1, 9, 64'h10020, 'h10020, 9, "R5");
    step(0, 0, 0, 'h10020, 9, "R5");
    // R7 low and unavailable indices ignored
    step(1, 2, 64'h10019, 'h10019, 2, "R7");
    step(1, 11, 64'h10019, 'h10019, 11, "R7");
    step(1, 0, 64'h1001B, 'h10019, 0, "R7");
    step(0, 0, 0, 'h1001B, 0, "R7");
    // Upper available index accepted
    step(1, 10, 64'h10019, 'h10019, 10, "R3");
    step(0, 0, 0, 'h10019, 10, "R10");
    // R6 remove every binding of counter 5
    step(1, 5, 64'h1001B, 'h1001B, 5, "R3");
    step(0, 0, 0, 'h1001B, 5, "R3");
    step(1, 5, 64'h0, 2, 5, "R6");
    step(0, 0, 0, 2, 5, "R6");
    step(0, 0, 0, 'h1001B, 5, "R6");
    step(0, 0, 0, 1, 6, "R6");
    // R6 remove with nothing bound
    step(1, 4, 64'h0, 'h10019, 4, "R6");
    step(0, 0, 0, 'h10019, 10, "R6");
    // Rebind freed code to another counter
    step(1, 8, 64'h2, 2, 8, "R3");
    step(1, 9, 64'h10021, 2, 8, "R9");
    step(1, 3, 64'h1001B, 'h10021, 9, "R3");
    // R6 remove of cycle binding clears mon_cycles for 6
    step(1, 6, 64'h0, 1, 6, "R6");
    step(0, 0, 0, 1, 6, "R6");
    // Sweep all codes against all monitor indices
    for (int k = 0; k < 6; k++) begin
      int code;
      case (k)
        0: code = 1; 1: code = 2; 2: code = 'h10019;
        3: code = 'h1001B; 4: code = 'h10021; default: code = 'h55;
      endcase
      for (int m = 0; m < 32; m++) step(0, 0, 0, code, m, "R3");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule